// File: doc/BRIEF.md
# Dual-Lane Serial Audio Receiver

This block receives audio from two serial data lanes. The lanes share one bit clock and one word-select line, and both come from an external transmitter, so the block is always a slave. The block's clock is the bit clock. On each rising edge it samples both data lines and the word-select line. It collects the bits of each half-frame (slot) into a parallel word, and it does this for both lanes together.

Two static control inputs set how a slot is read. The framing input picks one of two layouts. In the delayed, MSB-first layout the most significant bit arrives one bit clock after word-select changes. In the right-justified layout the least significant bit is the last bit before word-select changes. The width input picks one of two word sizes: a 16-bit compressed-bitstream word, or a PCM sample of up to 20 bits. Each finished word comes out left-aligned in a 20-bit field, with a left/right tag and a one-cycle valid strobe per lane.

Framing is run by a four-state controller:
- `ST_PRIME` takes the first word-select sample after reset and always moves to `ST_HUNT`.
- `ST_HUNT` discards bits until the first word-select edge, then moves to `ST_FILL`.
- `ST_FILL` collects bits. In the delayed layout it moves to `ST_DRAIN` once the word length is reached. On a word-select edge it emits the word and starts a new slot, staying in `ST_FILL`.
- `ST_DRAIN` discards the excess bits of the slot. On a word-select edge it emits the word and returns to `ST_FILL`.

Top module: `serial_audio_rx`

## Requirements
- R1: Both lanes are sampled on the same bit-clock edge and framed by the same word-select signal. Their valid strobes always assert in the same cycle, each carrying its own lane's data.
- R2: In the delayed layout (`cfg_lsb_just`=0), the bit sampled in the first cycle that shows a new word-select value is the last bit of the previous slot. The next sampled bit is the MSB of the new word. Bits are placed MSB-first from bit 19 of the output field downward.
- R3: `out_right` is 0 for a word received while word-select was low (left slot) and 1 for a word received while it was high (right slot).
- R4: With `cfg_pcm`=0 the word is 16 bits. It occupies output bits 19:4, and bits 3:0 are zero. Slot bits beyond the 16 that belong to the word are discarded.
- R5: With `cfg_pcm`=1 the word is 20 bits and occupies output bits 19:0.
- R6: In the delayed layout, if a slot carries fewer bits than the word length, the missing low-order output bits are zero.
- R7: In the right-justified layout (`cfg_lsb_just`=1), the word is the last word-length bits sampled before the word-select change, with the LSB being the final one. Earlier bits of the slot are ignored.
- R8: In the right-justified layout, if a slot is shorter than the word length, the output bits above the received bits are zero.
- R9: `out_valid` pulses for exactly one cycle. It is high in the cycle right after the sample that shows the word-select change ending the slot.
- R10: The partial slot in progress when reset is released produces no word. The first word out is the first complete slot.
- R11: A change of either control input takes effect at the next word-select edge. The slot in progress is finished in the old mode.
- R12: While reset is asserted, `out_valid`, `out_right` and `out_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lsb_just | input | 1 | Framing: 0 delayed MSB-first, 1 right-justified |
| cfg_pcm | input | 1 | Word size: 0 = 16-bit coded word, 1 = 20-bit PCM |
| ws | input | 1 | Word select: low = left slot, high = right slot |
| sd | input | LANES (2) | Serial data, one bit per lane |
| out_valid | output | LANES (2) | One-cycle strobe per lane when a word is presented |
| out_right | output | 1 | Channel tag of the presented words |
| out_word | output | LANES*WORD_MAX (40) | Left-aligned words; lane n at bits [n*20 +: 20] |

## Verification
If the state or bit counter is wrong, the fault shows in the very next emitted word. The result is a word shifted by one bit position, a nonzero low nibble in coded mode, or a stray bit from the previous slot, so the failure is visible one bit clock after the slot ends. If the word-select history register is wrong, `out_valid` strobes at the wrong place or carries the wrong tag. If the mode is latched at the wrong time, only the slot that straddles a control change is damaged. For that reason the bench switches the width in the middle of a slot and compares both the slot in progress and the following slot.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_PRIME,
        ST_HUNT,
        ST_FILL,
        ST_DRAIN
    } sar_state_e;

    typedef struct packed {
        logic lsb_just;
        logic pcm;
    } sar_mode_t;

endpackage

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
    import sar_pkg::*;
#(
    parameter int WORD_MAX   = 20,
    parameter int CODED_BITS = 16,
    localparam int PW = $clog2(WORD_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ws,
    input  sar_mode_t     cfg,
    output logic          restart,
    output logic          emit,
    output logic          bit_wr,
    output logic [PW-1:0] bit_pos,
    output sar_mode_t     act_mode,
    output logic          right_tag
);

    localparam logic [PW-1:0] LAST_PCM   = PW'(WORD_MAX - 1);
    localparam logic [PW-1:0] LAST_CODED = PW'(CODED_BITS - 1);

    sar_state_e    state, state_nx;
    logic          ws_q;
    logic          ws_edge;
    logic [PW-1:0] cnt;
    logic [PW-1:0] last_pos;

    assign ws_edge  = (ws != ws_q);
    assign last_pos = act_mode.pcm ? LAST_PCM : LAST_CODED;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: state_nx = ST_HUNT;
            ST_HUNT:  if (ws_edge) state_nx = ST_FILL;
            ST_FILL: begin
                if (ws_edge)
                    state_nx = ST_FILL;
                else if (!act_mode.lsb_just && (cnt == last_pos))
                    state_nx = ST_DRAIN;
            end
            ST_DRAIN: if (ws_edge) state_nx = ST_FILL;
            default:  state_nx = ST_PRIME;
        endcase
    end

    // outputs
    always_comb begin
        restart = 1'b0;
        emit    = 1'b0;
        bit_wr  = 1'b0;
        unique case (state)
            ST_PRIME: ;
            ST_HUNT:  restart = ws_edge;
            ST_FILL: begin
                restart = ws_edge;
                emit    = ws_edge;
                bit_wr  = !act_mode.lsb_just;
            end
            ST_DRAIN: begin
                restart = ws_edge;
                emit    = ws_edge;
            end
            default: ;
        endcase
    end

    assign bit_pos   = cnt;
    assign right_tag = ws_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q     <= 1'b0;
            cnt      <= '0;
            act_mode <= '0;
        end else begin
            ws_q <= ws;
            if (restart) begin
                cnt      <= '0;
                act_mode <= cfg;
            end else if (bit_wr) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_lane.sv
module sar_lane #(
    parameter int WORD_MAX   = 20,
    parameter int CODED_BITS = 16,
    localparam int PW = $clog2(WORD_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd,
    input  logic                restart,
    input  logic                bit_wr,
    input  logic [PW-1:0]       bit_pos,
    input  logic                act_lsb,
    input  logic                act_pcm,
    input  logic                new_lsb,
    output logic [WORD_MAX-1:0] word_fin
);

    logic [WORD_MAX-1:0] acc;
    logic [WORD_MAX-1:0] ins;
    logic [WORD_MAX-1:0] rj_word;
    logic [WORD_MAX-1:0] rj_coded;
    logic [PW-1:0]       idx;

    assign idx = PW'(WORD_MAX - 1) - bit_pos;
    assign ins = acc | (WORD_MAX'(sd) << idx);

    generate
        if (WORD_MAX > CODED_BITS) begin : g_pad
            assign rj_coded = {acc[CODED_BITS-1:0], {(WORD_MAX - CODED_BITS){1'b0}}};
        end else begin : g_nopad
            assign rj_coded = acc;
        end
    endgenerate

    assign rj_word  = act_pcm ? acc : rj_coded;
    assign word_fin = act_lsb ? rj_word : (bit_wr ? ins : acc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (restart) begin
            acc <= new_lsb ? WORD_MAX'(sd) : '0;
        end else if (act_lsb) begin
            acc <= {acc[WORD_MAX-2:0], sd};
        end else if (bit_wr) begin
            acc <= ins;
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int WORD_MAX   = 20,
    parameter int CODED_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_lsb_just,
    input  logic                      cfg_pcm,
    input  logic                      ws,
    input  logic [LANES-1:0]          sd,
    output logic [LANES-1:0]          out_valid,
    output logic                      out_right,
    output logic [LANES*WORD_MAX-1:0] out_word
);

    localparam int PW = $clog2(WORD_MAX + 1);

    sar_mode_t           cfg;
    sar_mode_t           act_mode;
    logic                restart, emit, bit_wr, right_tag;
    logic                act_pcm;
    logic [PW-1:0]       bit_pos;
    logic [WORD_MAX-1:0] fin [LANES];

    assign cfg.lsb_just = cfg_lsb_just;
    assign cfg.pcm      = cfg_pcm;
    assign act_pcm      = act_mode.pcm;

    sar_frame_ctrl #(
        .WORD_MAX   (WORD_MAX),
        .CODED_BITS (CODED_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ws        (ws),
        .cfg       (cfg),
        .restart   (restart),
        .emit      (emit),
        .bit_wr    (bit_wr),
        .bit_pos   (bit_pos),
        .act_mode  (act_mode),
        .right_tag (right_tag)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            sar_lane #(
                .WORD_MAX   (WORD_MAX),
                .CODED_BITS (CODED_BITS)
            ) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .sd       (sd[g]),
                .restart  (restart),
                .bit_wr   (bit_wr),
                .bit_pos  (bit_pos),
                .act_lsb  (act_mode.lsb_just),
                .act_pcm  (act_mode.pcm),
                .new_lsb  (cfg_lsb_just),
                .word_fin (fin[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_right <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= emit ? '1 : '0;
            if (emit) begin
                out_right <= right_tag;
                for (int i = 0; i < LANES; i++)
                    out_word[i*WORD_MAX +: WORD_MAX] <= fin[i];
            end
        end
    end

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
    parameter int LANES      = 2,
    parameter int WORD_MAX   = 20,
    parameter int CODED_BITS = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ws,
    input logic [LANES-1:0]          out_valid,
    input logic                      out_right,
    input logic [LANES*WORD_MAX-1:0] out_word,
    input logic                      act_pcm
);

    localparam int PAD = WORD_MAX - CODED_BITS;
    localparam logic [WORD_MAX-1:0] PAD_MASK = WORD_MAX'((64'd1 << PAD) - 64'd1);

    // R1
    p_lanes_lockstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == '0) || (out_valid == '1));

    // R9
    p_valid_after_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> ($past(ws) != $past(ws, 2)));

    // R9
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |=> !out_valid[0]);

    // R3
    p_tag_matches_ws_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> (out_right == $past(ws, 2)));

    // R4
    p_coded_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && !$past(act_pcm)) |->
            (((out_word[WORD_MAX-1:0] & PAD_MASK) == '0) &&
             ((out_word[LANES*WORD_MAX-1 -: WORD_MAX] & PAD_MASK) == '0)));

endmodule

bind serial_audio_rx sar_checker #(
    .LANES      (LANES),
    .WORD_MAX   (WORD_MAX),
    .CODED_BITS (CODED_BITS)
) u_sar_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ws        (ws),
    .out_valid (out_valid),
    .out_right (out_right),
    .out_word  (out_word),
    .act_pcm   (act_pcm)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

    localparam int LANES = 2;
    localparam int W     = 20;
    localparam int C     = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_lsb_just;
    logic             cfg_pcm;
    logic             ws;
    logic [LANES-1:0] sd;
    logic [LANES-1:0] out_valid;
    logic             out_right;
    logic [LANES*W-1:0] out_word;

    always #10 clk = ~clk;

    serial_audio_rx #(.LANES(LANES), .WORD_MAX(W), .CODED_BITS(C)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_lsb_just(cfg_lsb_just), .cfg_pcm(cfg_pcm),
        .ws(ws), .sd(sd), .out_valid(out_valid), .out_right(out_right), .out_word(out_word)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [W-1:0] cw0 [0:63];
    logic [W-1:0] cw1 [0:63];
    logic         cr  [0:63];
    bit           ce  [0:63];
    int           ncap;
    logic [W-1:0] ew0 [0:63];
    logic [W-1:0] ew1 [0:63];
    logic         er  [0:63];
    int           nexp;
    bit           sampled_edge;
    logic         pend0, pend1;
    int           slot_k = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one bit period: observe the previous edge's result, then drive new inputs
    task automatic step(input logic w, input logic b0, input logic b1);
        @(negedge clk);
        if (out_valid != '0) begin
            check(out_valid == 2'b11, "R1", "lanes strobe together", 64'(out_valid), 64'h3);
            if (ncap < 64) begin
                cw0[ncap] = out_word[W-1:0];
                cw1[ncap] = out_word[2*W-1:W];
                cr[ncap]  = out_right;
                ce[ncap]  = sampled_edge;
                ncap++;
            end
        end
        sampled_edge = (w != ws);
        ws    = w;
        sd[0] = b0;
        sd[1] = b1;
    endtask

    function automatic logic [W-1:0] exp_word(input logic [31:0] d, input int n,
                                              input bit lsb, input bit pcm);
        int len = pcm ? W : C;
        int k   = (n < len) ? n : len;
        logic [W-1:0] r = '0;
        for (int i = 0; i < k; i++) begin
            if (!lsb) r[W-1-i]     = d[n-1-i];
            else      r[W-len+i]   = d[i];
        end
        return r;
    endfunction

    task automatic do_reset(input bit lsb, input bit pcm);
        rst_n = 1'b0;
        cfg_lsb_just = lsb;
        cfg_pcm = pcm;
        ws = 1'b1;
        sd = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == '0, "R12", "valid in reset", 64'(out_valid), 64'h0);
        check(out_right == 1'b0, "R12", "tag in reset", 64'(out_right), 64'h0);
        check(out_word == '0, "R12", "word in reset", 64'(out_word), 64'h0);
        rst_n = 1'b1;
        ncap = 0;
        nexp = 0;
        sampled_edge = 1'b0;
        pend0 = 1'b1;
        pend1 = 1'b1;
        // partial slot with junk bits, R10
        repeat (5) step(1'b1, 1'b1, 1'b1);
    endtask

    task automatic send_slot(input logic v, input int n, input int chg_at, input bit chg_pcm);
        logic [31:0] d0, d1;
        bit lsb_for, pcm_for;
        logic b0, b1;
        d0 = 32'h9A3C_5E71 ^ (32'(slot_k) * 32'h1F2D_3C4B);
        d1 = {d0[15:0], d0[31:16]} ^ 32'h5555_AAAA;
        slot_k++;
        lsb_for = cfg_lsb_just;
        pcm_for = cfg_pcm;
        ew0[nexp] = exp_word(d0, n, lsb_for, pcm_for);
        ew1[nexp] = exp_word(d1, n, lsb_for, pcm_for);
        er[nexp]  = v;
        nexp++;
        for (int i = 0; i < n; i++) begin
            if (i == chg_at) cfg_pcm = chg_pcm;
            if (!lsb_for) begin
                b0 = (i == 0) ? pend0 : d0[n-i];
                b1 = (i == 0) ? pend1 : d1[n-i];
            end else begin
                b0 = d0[n-1-i];
                b1 = d1[n-1-i];
            end
            step(v, b0, b1);
        end
        if (!lsb_for) begin
            pend0 = d0[0];
            pend1 = d1[0];
        end
    endtask

    task automatic close_and_compare(input string req);
        logic nv;
        nv = ~ws;
        step(nv, pend0, pend1);
        step(nv, 1'b0, 1'b0);
        step(nv, 1'b0, 1'b0);
        check(ncap == nexp, "R10", "word count", 64'(ncap), 64'(nexp));
        for (int k = 0; k < nexp && k < ncap; k++) begin
            check(cw0[k] == ew0[k], req, $sformatf("lane0 word %0d", k), 64'(cw0[k]), 64'(ew0[k]));
            check(cw1[k] == ew1[k], req, $sformatf("lane1 word %0d", k), 64'(cw1[k]), 64'(ew1[k]));
            check(cr[k] == er[k], "R3", $sformatf("tag %0d", k), 64'(cr[k]), 64'(er[k]));
            check(ce[k], "R9", $sformatf("strobe timing %0d", k), 64'(ce[k]), 64'h1);
        end
    endtask

    // R2 R4: delayed framing, coded words, long slots discard excess
    task automatic t_delayed_coded();
        do_reset(1'b0, 1'b0);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 32, -1, 1'b0);
        send_slot(1'b0, 24, -1, 1'b0);
        send_slot(1'b1, 16, -1, 1'b0);
        close_and_compare("R2 R4");
    endtask

    // R5 R6: delayed framing, PCM, including a short slot
    task automatic t_delayed_pcm();
        do_reset(1'b0, 1'b1);
        send_slot(1'b0, 24, -1, 1'b0);
        send_slot(1'b1, 20, -1, 1'b0);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 18, -1, 1'b0);
        close_and_compare("R5 R6");
    endtask

    // R7 R8: right-justified PCM, including a slot shorter than the word
    task automatic t_rj_pcm();
        do_reset(1'b1, 1'b1);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 24, -1, 1'b0);
        send_slot(1'b0, 16, -1, 1'b0);
        send_slot(1'b1, 20, -1, 1'b0);
        close_and_compare("R7 R8");
    endtask

    // R7 R4: right-justified coded words
    task automatic t_rj_coded();
        do_reset(1'b1, 1'b0);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 17, -1, 1'b0);
        send_slot(1'b0, 24, -1, 1'b0);
        close_and_compare("R7 R4");
    endtask

    // R11: width changes mid-slot, applies from the next slot
    task automatic t_mode_change();
        do_reset(1'b0, 1'b0);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 32, 10, 1'b1);
        send_slot(1'b0, 32, -1, 1'b0);
        send_slot(1'b1, 24, 5, 1'b0);
        send_slot(1'b0, 32, -1, 1'b0);
        close_and_compare("R11");
    endtask

    initial begin
        t_delayed_coded();
        t_delayed_pcm();
        t_rj_pcm();
        t_rj_coded();
        t_mode_change();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule